// File: doc/BRIEF.md
# Miss and Writeback Issue Arbiter

This block sits between a cache's miss queue, its write buffer and a prefetch source, and picks which of them sends the next request onto the memory bus. Each queue is visible only through its head entry: a line address, a wrapping age stamp and, for misses, a ready time and a command with its attributes. The queues also report their pending-entry counts, full flags and, for the write buffer, how many entries are already in service. The storage behind these heads is outside the block.

The choice is made combinationally from the head signals. It is registered into a grant with a source select, line address and two attributes, line fill and no-allocate. The grant is held until the bus accepts it with a valid/ready handshake. On acceptance, the winning queue gets a one-cycle in-service mark. The block keeps a bus-request line and a stall flag for each queue. It updates them as entries are allocated and marked in service, and as the full flags change.

The policy favours ready misses. It turns to the write buffer under buffer pressure, or when no miss can go. Two same-line hazards are handled in opposite directions. An older miss holds back a writeback to its line, and a pending writeback to a line goes out before a miss to that same line.

Top module: `mwb_issue_arb`

## Requirements
- R1: A miss head with a nonzero pending count is ready once its ready time is not in the future, with `mq_time - now` read modulo 2^TIME_W so that zero or a negative value means ready. When chosen, it is granted with source code 1 (miss) and its own address.
- R2: The write buffer (source code 2) is chosen over the miss queue whenever it has a pending entry and at least one of these holds: it is full with zero entries in service, the miss queue has nothing pending, or the miss head is not ready.
- R3: When R2 selects the write buffer and the two heads fall in the same line (address bits above BLK_OFF equal), an older miss stamp wins. Older means the top bit of `mq_age - wb_age` is set. The ready miss is then granted instead; if that miss is not ready, nothing is granted.
- R4: When R2 does not apply and a ready miss would win, a pending writeback head in the same line is granted first, whatever the ages.
- R5: Only when neither queue has a pending entry, the miss queue is not full and the prefetch source is valid, the prefetch address is granted with source code 3. `pf_take` pulses in the deciding cycle so the prefetch is allocated as a miss.
- R6: Commands are encoded 0 read, 1 write, 2 upgrade and 3 invalidate. A miss grant for an upgrade or invalidate carries no-allocate 1 and line fill 0. Any other miss grant carries no-allocate equal to `mq_noalloc` and line fill equal to neither uncacheable nor no-allocate. Writebacks carry 0 for both, and prefetches carry line fill 1 and no-allocate 0.
- R7: A decision made in a cycle with no grant outstanding is presented the next cycle and held unchanged until `gnt_rdy`. In the accepting cycle exactly one of `mq_mark` or `wb_mark` pulses (a prefetch marks the miss queue). No new grant appears in the cycle after an acceptance.
- R8: An allocation pulse raises that queue's request line. An in-service mark made while the queue's pending count is at most 1, with no allocation in the same cycle, drops it. A mark with more entries pending leaves it high.
- R9: A queue's stall flag rises the cycle after its full flag rises. It is cleared only when a mark was made while full and the full flag is low the following cycle. A full flag that falls with no mark, or a mark made while not full, leaves the stall flag set.
- R10: After reset every output is low. While no source offers anything, the grant stays low and the request and stall flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now | input | TIME_W | Current time |
| mq_pend_cnt | input | CNT_W | Miss entries pending issue |
| mq_addr | input | ADDR_W | Miss head address |
| mq_age | input | AGE_W | Miss head age stamp |
| mq_time | input | TIME_W | Miss head ready time |
| mq_cmd | input | 2 | Miss head bus command |
| mq_uncached | input | 1 | Miss head is uncacheable |
| mq_noalloc | input | 1 | Miss head is no-allocate |
| mq_full | input | 1 | Miss queue full |
| mq_alloc | input | 1 | Miss entry allocated this cycle |
| wb_pend_cnt | input | CNT_W | Write-buffer entries pending issue |
| wb_insvc_cnt | input | CNT_W | Write-buffer entries in service |
| wb_addr | input | ADDR_W | Write-buffer head address |
| wb_age | input | AGE_W | Write-buffer head age stamp |
| wb_full | input | 1 | Write buffer full |
| wb_alloc | input | 1 | Write-buffer entry allocated this cycle |
| pf_vld | input | 1 | Prefetch request available |
| pf_addr | input | ADDR_W | Prefetch address |
| gnt_rdy | input | 1 | Bus accepts the grant |
| gnt_vld | output | 1 | Grant valid |
| gnt_src | output | 2 | Grant source: 1 miss, 2 writeback, 3 prefetch |
| gnt_addr | output | ADDR_W | Granted address |
| gnt_fill | output | 1 | Granted request is a line fill |
| gnt_noalloc | output | 1 | Granted request is no-allocate |
| pf_take | output | 1 | Prefetch consumed this cycle |
| mq_mark | output | 1 | Miss entry marked in service |
| wb_mark | output | 1 | Write-buffer entry marked in service |
| mq_req | output | 1 | Miss queue bus-request line |
| wb_req | output | 1 | Write-buffer bus-request line |
| mq_stall | output | 1 | Miss queue full stall |
| wb_stall | output | 1 | Write-buffer full stall |

## Verification
The bench builds the arbiter with a 4-bit age stamp, an 8-bit time, 16-bit addresses and 16-byte lines. These sizes let a handful of literal values push both age and ready time across their wrap point, so the modular older and not-in-future comparisons are tested at the boundary. With 16-byte lines, two addresses eight bytes apart share a line while looking different, which is what brings both same-line hazard directions within reach. The default depths of four keep pending counts of 0, 1 and 2 meaningful for the request-line rule.

// File: rtl/mwb_arb_pkg.sv
package mwb_arb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MISS = 2'd1,
    SRC_WB   = 2'd2,
    SRC_PF   = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    CMD_READ    = 2'd0,
    CMD_WRITE   = 2'd1,
    CMD_UPGRADE = 2'd2,
    CMD_INVAL   = 2'd3
  } cmd_e;
endpackage

// File: rtl/mwb_pick.sv
module mwb_pick
  import mwb_arb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BLK_OFF = 6,
  parameter int AGE_W   = 8,
  parameter int TIME_W  = 16,
  parameter int CNT_W   = 3
) (
  input  logic [TIME_W-1:0] now,
  input  logic [CNT_W-1:0]  mq_pend_cnt,
  input  logic [ADDR_W-1:0] mq_addr,
  input  logic [AGE_W-1:0]  mq_age,
  input  logic [TIME_W-1:0] mq_time,
  input  logic              mq_full,
  input  logic [CNT_W-1:0]  wb_pend_cnt,
  input  logic [CNT_W-1:0]  wb_insvc_cnt,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [AGE_W-1:0]  wb_age,
  input  logic              wb_full,
  input  logic              pf_vld,
  input  logic [ADDR_W-1:0] pf_addr,
  output src_e              pick,
  output logic [ADDR_W-1:0] pick_addr
);
  localparam int LINE_W = ADDR_W - BLK_OFF;

  logic              mq_has, wb_has;
  logic [TIME_W-1:0] t_delta;
  logic              mq_future, mq_ready;
  logic [AGE_W-1:0]  age_delta;
  logic              mq_older, same_line, wb_turn;
  logic [LINE_W-1:0] mq_line, wb_line;

  assign mq_has    = (mq_pend_cnt != '0);
  assign wb_has    = (wb_pend_cnt != '0);
  // Ready time compared modulo 2^TIME_W: a positive distance is the future.
  assign t_delta   = mq_time - now;
  assign mq_future = (t_delta != '0) && !t_delta[TIME_W-1];
  assign mq_ready  = mq_has && !mq_future;
  // Wrapping age stamps: negative difference means the miss is older.
  assign age_delta = mq_age - wb_age;
  assign mq_older  = age_delta[AGE_W-1];
  assign mq_line   = mq_addr[ADDR_W-1:BLK_OFF];
  assign wb_line   = wb_addr[ADDR_W-1:BLK_OFF];
  assign same_line = mq_has && wb_has && (mq_line == wb_line);
  assign wb_turn   = wb_has && ((wb_full && (wb_insvc_cnt == '0)) || !mq_has || mq_future);

  always_comb begin
    pick = SRC_NONE;
    if (wb_turn) begin
      if (same_line && mq_older) pick = mq_ready ? SRC_MISS : SRC_NONE;
      else                       pick = SRC_WB;
    end else if (mq_has) begin
      if (mq_ready) pick = same_line ? SRC_WB : SRC_MISS;
    end else if (pf_vld && !mq_full) begin
      pick = SRC_PF;
    end
  end

  always_comb begin
    unique case (pick)
      SRC_MISS: pick_addr = mq_addr;
      SRC_WB:   pick_addr = wb_addr;
      SRC_PF:   pick_addr = pf_addr;
      default:  pick_addr = '0;
    endcase
  end
endmodule

// File: rtl/mwb_attr.sv
module mwb_attr
  import mwb_arb_pkg::*;
(
  input  src_e       src,
  input  logic [1:0] cmd,
  input  logic       uncached,
  input  logic       noalloc_in,
  output logic       fill,
  output logic       noalloc
);
  always_comb begin
    fill    = 1'b0;
    noalloc = 1'b0;
    unique case (src)
      SRC_MISS: begin
        if (cmd == CMD_UPGRADE || cmd == CMD_INVAL) begin
          noalloc = 1'b1;
        end else begin
          noalloc = noalloc_in;
          fill    = !uncached && !noalloc_in;
        end
      end
      SRC_PF:  fill = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mwb_qflags.sv
module mwb_qflags #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             mark,
  input  logic [CNT_W-1:0] pend_cnt,
  input  logic             full,
  output logic             req,
  output logic             stall
);
  logic full_q;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      req    <= 1'b0;
      stall  <= 1'b0;
      full_q <= 1'b0;
      armed  <= 1'b0;
    end else begin
      full_q <= full;
      armed  <= mark && full;
      if (alloc)                                req <= 1'b1;
      else if (mark && pend_cnt <= CNT_W'(1))   req <= 1'b0;
      if (full && !full_q)                      stall <= 1'b1;
      else if (armed && !full)                  stall <= 1'b0;
    end
  end
endmodule

// File: rtl/mwb_issue_arb.sv
module mwb_issue_arb
  import mwb_arb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BLK_OFF  = 6,
  parameter int AGE_W    = 8,
  parameter int TIME_W   = 16,
  parameter int MQ_DEPTH = 4,
  parameter int WB_DEPTH = 4,
  localparam int MAX_D   = (MQ_DEPTH > WB_DEPTH) ? MQ_DEPTH : WB_DEPTH,
  localparam int CNT_W   = $clog2(MAX_D + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] now,
  input  logic [CNT_W-1:0]  mq_pend_cnt,
  input  logic [ADDR_W-1:0] mq_addr,
  input  logic [AGE_W-1:0]  mq_age,
  input  logic [TIME_W-1:0] mq_time,
  input  logic [1:0]        mq_cmd,
  input  logic              mq_uncached,
  input  logic              mq_noalloc,
  input  logic              mq_full,
  input  logic              mq_alloc,
  input  logic [CNT_W-1:0]  wb_pend_cnt,
  input  logic [CNT_W-1:0]  wb_insvc_cnt,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [AGE_W-1:0]  wb_age,
  input  logic              wb_full,
  input  logic              wb_alloc,
  input  logic              pf_vld,
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic              gnt_rdy,
  output logic              gnt_vld,
  output logic [1:0]        gnt_src,
  output logic [ADDR_W-1:0] gnt_addr,
  output logic              gnt_fill,
  output logic              gnt_noalloc,
  output logic              pf_take,
  output logic              mq_mark,
  output logic              wb_mark,
  output logic              mq_req,
  output logic              wb_req,
  output logic              mq_stall,
  output logic              wb_stall
);
  localparam int NQ = 2;  // queue 0: misses, queue 1: write buffer

  src_e              pick;
  logic [ADDR_W-1:0] pick_addr;
  logic              pick_fill, pick_noalloc;
  logic              load_en, accept;

  mwb_pick #(
    .ADDR_W(ADDR_W), .BLK_OFF(BLK_OFF), .AGE_W(AGE_W),
    .TIME_W(TIME_W), .CNT_W(CNT_W)
  ) u_pick (
    .now(now), .mq_pend_cnt(mq_pend_cnt), .mq_addr(mq_addr), .mq_age(mq_age),
    .mq_time(mq_time), .mq_full(mq_full), .wb_pend_cnt(wb_pend_cnt),
    .wb_insvc_cnt(wb_insvc_cnt), .wb_addr(wb_addr), .wb_age(wb_age),
    .wb_full(wb_full), .pf_vld(pf_vld), .pf_addr(pf_addr),
    .pick(pick), .pick_addr(pick_addr)
  );

  mwb_attr u_attr (
    .src(pick), .cmd(mq_cmd), .uncached(mq_uncached), .noalloc_in(mq_noalloc),
    .fill(pick_fill), .noalloc(pick_noalloc)
  );

  assign load_en = !gnt_vld && (pick != SRC_NONE);
  assign accept  = gnt_vld && gnt_rdy;
  assign pf_take = load_en && (pick == SRC_PF);
  assign mq_mark = accept && (gnt_src == SRC_MISS || gnt_src == SRC_PF);
  assign wb_mark = accept && (gnt_src == SRC_WB);

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_vld     <= 1'b0;
      gnt_src     <= SRC_NONE;
      gnt_addr    <= '0;
      gnt_fill    <= 1'b0;
      gnt_noalloc <= 1'b0;
    end else if (accept) begin
      gnt_vld <= 1'b0;
    end else if (load_en) begin
      gnt_vld     <= 1'b1;
      gnt_src     <= pick;
      gnt_addr    <= pick_addr;
      gnt_fill    <= pick_fill;
      gnt_noalloc <= pick_noalloc;
    end
  end

  logic [NQ-1:0]            q_alloc, q_mark, q_full, q_req, q_stall;
  logic [NQ-1:0][CNT_W-1:0] q_cnt;

  assign q_alloc = {wb_alloc, mq_alloc};
  assign q_mark  = {wb_mark, mq_mark};
  assign q_full  = {wb_full, mq_full};
  assign q_cnt   = {wb_pend_cnt, mq_pend_cnt};

  for (genvar q = 0; q < NQ; q++) begin : g_q
    mwb_qflags #(.CNT_W(CNT_W)) u_flags (
      .clk(clk), .rst(rst), .alloc(q_alloc[q]), .mark(q_mark[q]),
      .pend_cnt(q_cnt[q]), .full(q_full[q]), .req(q_req[q]), .stall(q_stall[q])
    );
  end

  assign mq_req   = q_req[0];
  assign wb_req   = q_req[1];
  assign mq_stall = q_stall[0];
  assign wb_stall = q_stall[1];
endmodule

// File: rtl/mwb_issue_arb_chk.sv
module mwb_issue_arb_chk
  import mwb_arb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TIME_W = 16,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [TIME_W-1:0] now,
  input logic [CNT_W-1:0]  mq_pend_cnt,
  input logic [TIME_W-1:0] mq_time,
  input logic [1:0]        mq_cmd,
  input logic              mq_full,
  input logic              mq_alloc,
  input logic [CNT_W-1:0]  wb_pend_cnt,
  input logic              wb_full,
  input logic              pf_vld,
  input logic              gnt_rdy,
  input logic              gnt_vld,
  input logic [1:0]        gnt_src,
  input logic [ADDR_W-1:0] gnt_addr,
  input logic              gnt_fill,
  input logic              gnt_noalloc,
  input logic              pf_take,
  input logic              mq_mark,
  input logic              wb_mark,
  input logic              mq_req,
  input logic              wb_stall
);
  logic [TIME_W-1:0] dt;
  logic              in_future;
  assign dt        = mq_time - now;
  assign in_future = (dt != '0) && !dt[TIME_W-1];

  AST_MISS_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_vld) && gnt_src == SRC_MISS |-> !$past(in_future)); // R1
  AST_PF_GATE: assert property (@(posedge clk) disable iff (rst)
    pf_take |-> pf_vld && !mq_full && mq_pend_cnt == '0 && wb_pend_cnt == '0); // R5
  AST_UPG_NOALLOC: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_vld) && gnt_src == SRC_MISS && $past(mq_cmd[1]) |-> gnt_noalloc && !gnt_fill); // R6
  AST_MARK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mq_mark, wb_mark})); // R7
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    gnt_vld && !gnt_rdy |=> gnt_vld && $stable(gnt_src) && $stable(gnt_addr)); // R7
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    mq_mark && mq_pend_cnt <= CNT_W'(1) && !mq_alloc |=> !mq_req); // R8
  AST_WB_STALL_CLR: assert property (@(posedge clk) disable iff (rst)
    $fell(wb_stall) |-> $past(wb_mark, 2) && $past(wb_full, 2) && !$past(wb_full)); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !gnt_vld && mq_pend_cnt == '0 && wb_pend_cnt == '0 && !pf_vld |=> !gnt_vld); // R10
endmodule

bind mwb_issue_arb mwb_issue_arb_chk #(
  .ADDR_W(ADDR_W), .TIME_W(TIME_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_mwb_issue_arb.sv
`timescale 1ns/1ps
module sim_mwb_issue_arb;
  localparam int AW = 16, BO = 4, GW = 4, TW = 8, CW = 3;
  localparam int PFA = 'h7770;

  logic          clk = 1'b0, rst = 1'b1;
  logic [TW-1:0] now;
  logic [CW-1:0] mq_pend_cnt, wb_pend_cnt, wb_insvc_cnt;
  logic [AW-1:0] mq_addr, wb_addr, pf_addr;
  logic [GW-1:0] mq_age, wb_age;
  logic [TW-1:0] mq_time;
  logic [1:0]    mq_cmd, gnt_src;
  logic mq_uncached, mq_noalloc, mq_full, mq_alloc, wb_full, wb_alloc, pf_vld, gnt_rdy;
  logic gnt_vld, gnt_fill, gnt_noalloc, pf_take, mq_mark, wb_mark;
  logic mq_req, wb_req, mq_stall, wb_stall;
  logic [AW-1:0] gnt_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mwb_issue_arb #(.ADDR_W(AW), .BLK_OFF(BO), .AGE_W(GW), .TIME_W(TW),
                  .MQ_DEPTH(4), .WB_DEPTH(4)) u0 (.*);

  typedef struct packed {
    int mqc; int mqa; int mqg; int mqt; int cmd; int unc; int na;
    int wbc; int wba; int wbg; int wbf; int wbi; int mqf; int pfv; int tnow;
    int xs; int xf; int xn; int xa; int tag;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1,'h1230,2,50,0,0,0, 0,'h4000,0,0,0, 0,0,100, 1,1,0,'h1230, 1}, // R1 ready miss
    '{1,'h1240,2,100,0,0,0, 0,0,0,0,0, 0,0,100, 1,1,0,'h1240, 1},    // R1 time equals now
    '{0,0,0,0,0,0,0, 1,'h4000,1,0,0, 0,0,100, 2,0,0,'h4000, 2},       // R2 no miss pending
    '{1,'h1230,2,50,0,0,0, 1,'h4000,1,0,0, 0,0,100, 1,1,0,'h1230, 1}, // R1 miss preferred
    '{1,'h1230,2,50,0,0,0, 1,'h4000,1,1,0, 0,0,100, 2,0,0,'h4000, 2}, // R2 full, none in service
    '{1,'h1230,2,50,0,0,0, 1,'h4000,1,1,1, 0,0,100, 1,1,0,'h1230, 2}, // R2 full but one in service
    '{1,'h1230,2,120,0,0,0, 1,'h4000,1,0,0, 0,0,100, 2,0,0,'h4000, 2},// R2 miss in future
    '{1,'h1230,3,50,0,0,0, 1,'h1238,5,1,0, 0,0,100, 1,1,0,'h1230, 3}, // R3 older miss wins
    '{1,'h1230,6,50,0,0,0, 1,'h1238,5,1,0, 0,0,100, 2,0,0,'h1238, 3}, // R3 younger miss loses
    '{1,'h1230,14,50,0,0,0, 1,'h1238,1,1,0, 0,0,100, 1,1,0,'h1230, 3},// R3 age wrap
    '{1,'h1230,3,120,0,0,0, 1,'h1238,5,0,0, 0,0,100, 0,0,0,0, 3},     // R3 older miss not ready
    '{1,'h1230,6,50,0,0,0, 1,'h1238,5,0,0, 0,0,100, 2,0,0,'h1238, 4}, // R4 writeback first
    '{1,'h1230,3,50,0,0,0, 1,'h1238,5,0,0, 0,0,100, 2,0,0,'h1238, 4}, // R4 regardless of age
    '{0,0,0,0,0,0,0, 0,0,0,0,0, 0,1,100, 3,1,0,'h7770, 5},            // R5 prefetch taken
    '{0,0,0,0,0,0,0, 0,0,0,0,0, 1,1,100, 0,0,0,0, 5},                 // R5 miss queue full
    '{1,'h1230,2,120,0,0,0, 0,0,0,0,0, 0,1,100, 0,0,0,0, 5},          // R5 miss waiting
    '{0,0,0,0,0,0,0, 1,'h4000,1,0,0, 0,1,100, 2,0,0,'h4000, 5},       // R5 writeback present
    '{1,'h2000,2,50,2,0,0, 0,0,0,0,0, 0,0,100, 1,0,1,'h2000, 6},      // R6 upgrade
    '{1,'h2000,2,50,3,0,0, 0,0,0,0,0, 0,0,100, 1,0,1,'h2000, 6},      // R6 invalidate
    '{1,'h2000,2,50,0,1,0, 0,0,0,0,0, 0,0,100, 1,0,0,'h2000, 6},      // R6 uncacheable
    '{1,'h2000,2,50,1,0,1, 0,0,0,0,0, 0,0,100, 1,0,1,'h2000, 6},      // R6 no-allocate
    '{1,'h2000,2,50,1,0,0, 0,0,0,0,0, 0,0,100, 1,1,0,'h2000, 6},      // R6 plain write fill
    '{1,'h3000,2,250,0,0,0, 0,0,0,0,0, 0,0,5, 1,1,0,'h3000, 1}        // R1 time wrap
  };

  task automatic chk(input int tag, input longint act, input longint exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    now = 100; mq_pend_cnt = 0; mq_addr = 0; mq_age = 0; mq_time = 0; mq_cmd = 0;
    mq_uncached = 0; mq_noalloc = 0; mq_full = 0; mq_alloc = 0;
    wb_pend_cnt = 0; wb_insvc_cnt = 0; wb_addr = 0; wb_age = 0; wb_full = 0;
    wb_alloc = 0; pf_vld = 0; pf_addr = PFA; gnt_rdy = 1;
  endtask

  task automatic do_reset();
    idle();
    rst = 1;
    tick(); tick();
    rst = 0;
  endtask

  task automatic apply(input vec_t v);
    mq_pend_cnt = v.mqc; mq_addr = v.mqa; mq_age = v.mqg; mq_time = v.mqt;
    mq_cmd = v.cmd; mq_uncached = v.unc; mq_noalloc = v.na;
    wb_pend_cnt = v.wbc; wb_addr = v.wba; wb_age = v.wbg; wb_full = v.wbf;
    wb_insvc_cnt = v.wbi; mq_full = v.mqf; pf_vld = v.pfv; now = v.tnow;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10: reset state
    chk(10, gnt_vld, 0, "gnt_vld after reset");
    chk(10, {mq_req, wb_req, mq_stall, wb_stall}, 0, "flags after reset");
    chk(10, {mq_mark, wb_mark, pf_take}, 0, "pulses after reset");

    // Table walk: R1..R6
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      #1;
      chk(VECS[i].tag, pf_take, (VECS[i].xs == 3), $sformatf("pf_take vec %0d", i));
      tick();
      chk(VECS[i].tag, gnt_vld, (VECS[i].xs != 0), $sformatf("gnt_vld vec %0d", i));
      if (VECS[i].xs != 0) begin
        chk(VECS[i].tag, gnt_src, VECS[i].xs, $sformatf("gnt_src vec %0d", i));
        chk(VECS[i].tag, gnt_addr, VECS[i].xa, $sformatf("gnt_addr vec %0d", i));
        chk(VECS[i].tag, gnt_fill, VECS[i].xf, $sformatf("gnt_fill vec %0d", i));
        chk(VECS[i].tag, gnt_noalloc, VECS[i].xn, $sformatf("gnt_noalloc vec %0d", i));
      end
      idle();
      tick();
    end

    // R7: hold while not ready, then accept
    do_reset();
    gnt_rdy = 0; mq_pend_cnt = 1; mq_addr = 'h5550; mq_time = 10;
    tick();
    chk(7, {gnt_vld, gnt_src}, 3'b101, "grant presented");
    mq_pend_cnt = 0; wb_pend_cnt = 1; wb_addr = 'h6000;
    tick(); tick();
    chk(7, {gnt_vld, gnt_src}, 3'b101, "grant held without ready");
    chk(7, gnt_addr, 'h5550, "address held");
    chk(7, {mq_mark, wb_mark}, 2'b00, "no mark while waiting");
    gnt_rdy = 1;
    #1;
    chk(7, {mq_mark, wb_mark}, 2'b10, "miss mark on accept");
    tick();
    chk(7, gnt_vld, 0, "gap after acceptance");
    tick();
    chk(7, {gnt_vld, gnt_src}, 3'b110, "next grant writeback");
    idle();
    tick();

    // R8: request lines
    do_reset();
    mq_alloc = 1;
    tick();
    mq_alloc = 0;
    chk(8, mq_req, 1, "alloc raises mq_req");
    mq_pend_cnt = 2; mq_time = 10;
    tick();
    mq_time = 200;
    tick();
    chk(8, mq_req, 1, "mark with two pending keeps mq_req");
    mq_pend_cnt = 1; mq_time = 10;
    tick();
    mq_time = 200;
    tick();
    chk(8, mq_req, 0, "mark of last pending drops mq_req");
    idle();
    wb_alloc = 1;
    tick();
    wb_alloc = 0;
    chk(8, wb_req, 1, "alloc raises wb_req");
    // R10: nothing offered, state held
    tick(); tick(); tick();
    chk(10, {gnt_vld, mq_req, wb_req}, 3'b001, "idle holds state");
    wb_pend_cnt = 1;
    tick();
    wb_pend_cnt = 0;
    tick();
    chk(8, wb_req, 0, "mark of last pending drops wb_req");

    // R9: write-buffer stall
    do_reset();
    gnt_rdy = 0; wb_full = 1; wb_pend_cnt = 1;
    tick();
    chk(9, wb_stall, 1, "wb_stall set on full rise");
    gnt_rdy = 1;
    tick();
    wb_full = 0; wb_pend_cnt = 0;
    tick();
    chk(9, wb_stall, 0, "wb_stall cleared after mark while full");
    wb_full = 1;
    tick();
    wb_full = 0;
    tick(); tick();
    chk(9, wb_stall, 1, "full falls without mark keeps wb_stall");
    wb_pend_cnt = 1;
    tick();
    wb_pend_cnt = 0;
    tick(); tick();
    chk(9, wb_stall, 1, "mark while not full keeps wb_stall");

    // R9: miss-queue stall
    do_reset();
    gnt_rdy = 0; mq_full = 1; mq_pend_cnt = 1; mq_time = 10;
    tick();
    chk(9, mq_stall, 1, "mq_stall set on full rise");
    gnt_rdy = 1;
    tick();
    mq_full = 0; mq_pend_cnt = 0;
    tick();
    chk(9, mq_stall, 0, "mq_stall cleared after mark while full");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule